// File: doc/BRIEF.md
# Mirror-Capable Four-Plane Pixel Serialiser

The block turns four bytes of bit-plane data into four serial pixel streams, one bit per plane per pixel clock. Two of the planes carry shape images and two carry character images. Every plane has a pair of shift registers. On a load strobe the first register takes the byte as given. The second register takes the same byte with its bit order reversed end to end. A flip input picks which register of each pair drives the output. The pick is the same for all four planes, so the whole picture can be mirrored left to right without reversing any byte when it is fetched.

A small sequencer runs the pairs. It has two states. In `SEQ_EMPTY` no byte is in flight and every register holds zeros. `SEQ_ACTIVE` is entered on a load and left for `SEQ_EMPTY` once the eighth shift completes with no new load. A load in `SEQ_ACTIVE` stays in `SEQ_ACTIVE` and restarts the bit count. The flip input is captured only on a load edge, so a mirror change always lands on a byte boundary.

Top module: `px_flip_shifter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released with no load, all four serial outputs are 0.
- R2: With flip captured as 0, the edge that loads a byte makes its bit 7 visible on the plane's output. Each following clock edge presents the next lower bit, ending with bit 0.
- R3: With flip captured as 1, the loaded byte is presented in reverse order: bit 0 first, bit 7 last, one bit per clock edge.
- R4: A load on an edge takes precedence over shifting. The first bit of the new byte appears at once, even if the previous byte is not yet fully shifted out.
- R5: After eight clock edges with no load since the last load, every output is 0, and it stays 0 until the next load.
- R6: The flip input is sampled only on load edges. Changing it between loads has no effect on the byte currently being shifted out.
- R7: The outputs map to the planes in this fixed order: out_shape1, out_shape2, out_char1, out_char2. A single flip value applies to all four planes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe, one cycle, every eight pixels |
| flip_i | input | 1 | Horizontal mirror request, captured on load |
| shape1_i | input | 8 | Shape plane 1 byte |
| shape2_i | input | 8 | Shape plane 2 byte |
| char1_i | input | 8 | Character plane 1 byte |
| char2_i | input | 8 | Character plane 2 byte |
| out_shape1 | output | 1 | Serial pixel bit, shape plane 1 |
| out_shape2 | output | 1 | Serial pixel bit, shape plane 2 |
| out_char1 | output | 1 | Serial pixel bit, character plane 1 |
| out_char2 | output | 1 | Serial pixel bit, character plane 2 |

## Verification
The first pixel of a byte is due in the same cycle as the edge that loads it, because only one register lies on the path and the output select is combinational. Pixel k is then due k edges after the load, and zeros are due from the eighth edge on. The bench drives inputs and samples outputs on the falling clock edge. It holds a load for exactly one rising edge and compares the outputs at each later falling edge against a model built from the bytes and the flip value it applied. This keeps every comparison a whole number of cycles from its stimulus.

// File: rtl/px_shift_pkg.sv
package px_shift_pkg;

    // Number of bit-planes handled in parallel.
    localparam int PLANES = 4;

    // Plane indices; their order fixes the output pin order.
    localparam int PL_SHAPE1 = 0;
    localparam int PL_SHAPE2 = 1;
    localparam int PL_CHAR1  = 2;
    localparam int PL_CHAR2  = 3;

    typedef enum logic [0:0] {
        SEQ_EMPTY  = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_t;

endpackage

// File: rtl/px_seq_ctrl.sv
module px_seq_ctrl
    import px_shift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       flip_i,
    output logic       shift_en_o,
    output logic       flip_sel_o,
    output seq_state_t state_o
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          flip_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_EMPTY:  if (load_i) state_d = SEQ_ACTIVE;
            SEQ_ACTIVE: begin
                if (load_i)              state_d = SEQ_ACTIVE;
                else if (cnt_q == LAST)  state_d = SEQ_EMPTY;
            end
            default:    state_d = SEQ_EMPTY;
        endcase
    end

    // Shift count and captured mirror select.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flip_q <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= '0;
            flip_q <= flip_i;
        end else if (state_q == SEQ_ACTIVE) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        shift_en_o = 1'b0;
        unique case (state_q)
            SEQ_EMPTY:  shift_en_o = 1'b0;
            SEQ_ACTIVE: shift_en_o = !load_i;
            default:    shift_en_o = 1'b0;
        endcase
    end

    assign flip_sel_o = flip_q;
    assign state_o    = state_q;

    AST_FLIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(flip_sel_o)); // R6

    AST_LOAD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_o == SEQ_ACTIVE)); // R4

endmodule

// File: rtl/px_shift_pair.sv
module px_shift_pair #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic         sel_i,
    input  logic [W-1:0] data_i,
    output logic         bit_o
);

    logic [W-1:0] data_rev;
    logic [W-1:0] fwd_q;
    logic [W-1:0] rev_q;

    for (genvar g = 0; g < W; g++) begin : g_rev
        assign data_rev[g] = data_i[W-1-g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_q <= '0;
            rev_q <= '0;
        end else if (load_i) begin
            fwd_q <= data_i;
            rev_q <= data_rev;
        end else if (shift_i) begin
            fwd_q <= {fwd_q[W-2:0], 1'b0};
            rev_q <= {rev_q[W-2:0], 1'b0};
        end
    end

    assign bit_o = sel_i ? rev_q[W-1] : fwd_q[W-1];

    AST_LOAD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (fwd_q == $past(data_i))); // R2

    AST_LOAD_REV_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (rev_q[W-1] == $past(data_i[0]))); // R3

    AST_NO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($countones(fwd_q) <= $past($countones(fwd_q)))); // R5

endmodule

// File: rtl/px_flip_shifter.sv
module px_flip_shifter
    import px_shift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         flip_i,
    input  logic [W-1:0] shape1_i,
    input  logic [W-1:0] shape2_i,
    input  logic [W-1:0] char1_i,
    input  logic [W-1:0] char2_i,
    output logic         out_shape1,
    output logic         out_shape2,
    output logic         out_char1,
    output logic         out_char2
);

    logic [W-1:0]      plane_d [PLANES];
    logic [PLANES-1:0] pix;
    logic              shift_en;
    logic              flip_sel;
    seq_state_t        seq_state;

    assign plane_d[PL_SHAPE1] = shape1_i;
    assign plane_d[PL_SHAPE2] = shape2_i;
    assign plane_d[PL_CHAR1]  = char1_i;
    assign plane_d[PL_CHAR2]  = char2_i;

    px_seq_ctrl #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .flip_i    (flip_i),
        .shift_en_o(shift_en),
        .flip_sel_o(flip_sel),
        .state_o   (seq_state)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        px_shift_pair #(.W(W)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load_i),
            .shift_i(shift_en),
            .sel_i  (flip_sel),
            .data_i (plane_d[p]),
            .bit_o  (pix[p])
        );
    end

    assign out_shape1 = pix[PL_SHAPE1];
    assign out_shape2 = pix[PL_SHAPE2];
    assign out_char1  = pix[PL_CHAR1];
    assign out_char2  = pix[PL_CHAR2];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (pix == '0)); // R1

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_EMPTY) |-> (pix == '0)); // R5

    AST_FIRST_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (out_char2 == ($past(flip_i) ? $past(char2_i[0])
                                                : $past(char2_i[W-1])))); // R7

endmodule

// File: tb/px_flip_shifter_test.sv
module px_flip_shifter_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic         flip_i = 1'b0;
    logic [W-1:0] shape1_i = '0;
    logic [W-1:0] shape2_i = '0;
    logic [W-1:0] char1_i = '0;
    logic [W-1:0] char2_i = '0;
    logic         out_shape1, out_shape2, out_char1, out_char2;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    px_flip_shifter #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .flip_i(flip_i),
        .shape1_i(shape1_i), .shape2_i(shape2_i),
        .char1_i(char1_i), .char2_i(char2_i),
        .out_shape1(out_shape1), .out_shape2(out_shape2),
        .out_char1(out_char1), .out_char2(out_char2)
    );

    function automatic logic [3:0] outs();
        return {out_shape1, out_shape2, out_char1, out_char2};
    endfunction

    // Expected bit k (0 = first pixel) of a byte under a mirror setting.
    function automatic logic pick(logic [W-1:0] b, int k, logic fl);
        if (k >= W) return 1'b0;
        return fl ? b[k] : b[W-1-k];
    endfunction

    task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: outputs %b, expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Drive one load across a single rising edge; returns at the next falling edge.
    task automatic do_load(logic [W-1:0] a, logic [W-1:0] b,
                           logic [W-1:0] c, logic [W-1:0] d, logic fl);
        shape1_i = a; shape2_i = b; char1_i = c; char2_i = d;
        flip_i = fl; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // Compare pixels first..last of the current byte, one per cycle.
    task automatic stream(string req, logic [W-1:0] a, logic [W-1:0] b,
                          logic [W-1:0] c, logic [W-1:0] d, logic fl,
                          int first, int last);
        for (int k = first; k <= last; k++) begin
            chk(req, outs(), {pick(a, k, fl), pick(b, k, fl), pick(c, k, fl), pick(d, k, fl)});
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", outs(), 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", outs(), 4'b0000);
    endtask

    // R2, R7: plain order, distinct byte per plane.
    task automatic t_plain();
        do_load(8'hA5, 8'h3C, 8'hF0, 8'h81, 1'b0);
        stream("R2", 8'hA5, 8'h3C, 8'hF0, 8'h81, 1'b0, 0, W-1);
    endtask

    // R3, R7: mirrored order on all planes.
    task automatic t_flip();
        do_load(8'hA5, 8'h3C, 8'hF0, 8'h81, 1'b1);
        stream("R3", 8'hA5, 8'h3C, 8'hF0, 8'h81, 1'b1, 0, W-1);
    endtask

    // R5: zeros after eight edges without a load, and they stay.
    task automatic t_drain();
        do_load(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0);
        stream("R5", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 0, W+2);
    endtask

    // R4: reload mid-byte restarts with the new byte's first pixel.
    task automatic t_override();
        do_load(8'h00, 8'hFF, 8'h0F, 8'hF0, 1'b0);
        stream("R4", 8'h00, 8'hFF, 8'h0F, 8'hF0, 1'b0, 0, 2);
        do_load(8'h80, 8'h01, 8'hC3, 8'h5A, 1'b1);
        stream("R4", 8'h80, 8'h01, 8'hC3, 8'h5A, 1'b1, 0, W);
    endtask

    // R6: a flip change between loads is ignored until the next load.
    task automatic t_flip_hold();
        do_load(8'h1E, 8'hB4, 8'h69, 8'h07, 1'b0);
        stream("R6", 8'h1E, 8'hB4, 8'h69, 8'h07, 1'b0, 0, 1);
        flip_i = 1'b1;
        stream("R6", 8'h1E, 8'hB4, 8'h69, 8'h07, 1'b0, 2, W-1);
        do_load(8'h1E, 8'hB4, 8'h69, 8'h07, 1'b1);
        flip_i = 1'b0;
        stream("R6", 8'h1E, 8'hB4, 8'h69, 8'h07, 1'b1, 0, W-1);
    endtask

    // R7: back-to-back bytes with the mirror swapped at the boundary.
    task automatic t_back2back();
        do_load(8'hC1, 8'h2D, 8'h70, 8'h9E, 1'b1);
        stream("R7", 8'hC1, 8'h2D, 8'h70, 8'h9E, 1'b1, 0, W-2);
        chk("R7", outs(), {pick(8'hC1, W-1, 1'b1), pick(8'h2D, W-1, 1'b1),
                           pick(8'h70, W-1, 1'b1), pick(8'h9E, W-1, 1'b1)});
        do_load(8'h36, 8'hE8, 8'h4B, 8'h11, 1'b0);
        stream("R7", 8'h36, 8'hE8, 8'h4B, 8'h11, 1'b0, 0, W);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_plain();
        t_flip();
        t_drain();
        t_override();
        t_flip_hold();
        t_back2back();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual hung, expected completion");
        finish_run();
    end

endmodule